// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that lives in memory. A requester presents an address while the walker is idle. The walker then reads one descriptor from the first-level table, which is located through a base-address input, and reads a second descriptor when the first one points to a second-level table. All reads go through a single-word read port with valid/ready handshakes. When the walk ends, the walker pulses a completion strobe. The completion results stay on the output registers until the next walk finishes:

- the physical address,
- the domain,
- the selected access-permission field,
- the cacheable and bufferable flags,
- a page-size code,
- a fault flag with the level that faulted.

A first-level entry either faults, maps a 1 MB section directly, or points to a second-level table. That table is either a coarse table (256 entries, one per 4 KB of the section) or a fine table (1024 entries, one per 1 KB). A second-level entry either faults or maps a 64 KB, 4 KB or 1 KB page. Large and small pages carry four permission fields, one for each quarter of the page, and the walker returns the field that the address falls in.

Top module: `xlat_walk`

## Requirements
- R1: After reset, `reqReady` is 1. `done`, `memReqValid`, `fault`, `faultLevel`, `paddr`, `domain`, `perm`, `cacheable`, `bufferable` and `pageSize` are all 0.
- R2: The first read of a walk is at address {tableBase[31:14], vaddr[31:20], 2'b00}. Bits [13:0] of `tableBase` have no effect.
- R3: A first-level descriptor whose bits [1:0] are 2 maps a section with one read.
  - Outputs: paddr = {d[31:20], vaddr[19:0]}, perm = d[11:10], domain = d[8:5], cacheable = d[3], bufferable = d[2], pageSize = 0.
- R4: A first-level descriptor with bits [1:0] = 1 points to a coarse table.
  - The second read is at {d[31:10], vaddr[19:12], 2'b00}.
  - With bits [1:0] = 3 it points to a fine table, and the second read is at {d[31:12], vaddr[19:10], 2'b00}.
  - In both cases `domain` is taken from the first-level d[8:5].
- R5: A second-level descriptor with bits [1:0] = 1 is a 64 KB page: paddr = {d[31:16], vaddr[15:0]}, pageSize = 1.
  - vaddr[15:14] selects the permission field: 0 selects d[5:4], 1 selects d[7:6], 2 selects d[9:8] and 3 selects d[11:10].
  - cacheable = d[3] and bufferable = d[2].
- R6: A second-level descriptor with bits [1:0] = 2 is a 4 KB page: paddr = {d[31:12], vaddr[11:0]}, pageSize = 2.
  - vaddr[11:10] selects the permission field with the same mapping as R5.
  - cacheable = d[3] and bufferable = d[2].
- R7: A second-level descriptor with bits [1:0] = 3 in a fine table is a 1 KB page: paddr = {d[31:10], vaddr[9:0]}, pageSize = 3, perm = d[5:4], cacheable = d[3], bufferable = d[2].
- R8: A first-level descriptor with bits [1:0] = 0 ends the walk after one read.
  - fault = 1 and faultLevel = 0.
  - paddr, domain, perm, cacheable, bufferable and pageSize are all 0.
- R9: A second-level descriptor with bits [1:0] = 0, or one with bits [1:0] = 3 found in a coarse table, ends the walk after two reads.
  - fault = 1 and faultLevel = 1, with all other result fields 0.
- R10: At most one read is outstanding at any time. While `memReqValid` is high and `memReqReady` is low, `memReqValid` and `memReqAddr` hold steady.
- R11: `reqReady` is high only while idle, and requests made while busy are ignored. `done` is a one-cycle pulse, and the result outputs change only on the cycle `done` is high.
- R12: With `memReqReady` held high and a memory answering one cycle after the handshake, `done` rises two clock edges after the accepting edge for a one-read walk and four edges after it for a two-read walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tableBase | input | 32 | First-level table base; low 14 bits ignored |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle, request accepted when reqValid is high |
| memReqValid | output | 1 | Descriptor read request |
| memReqAddr | output | 32 | Descriptor word address (byte address, word aligned) |
| memReqReady | input | 1 | Memory accepts the read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Descriptor word returned |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 32 | Translated physical address |
| domain | output | 4 | Domain from the first-level descriptor |
| perm | output | 2 | Selected access-permission field |
| cacheable | output | 1 | Cacheable flag |
| bufferable | output | 1 | Bufferable flag |
| pageSize | output | 2 | 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 1 KB |
| fault | output | 1 | Translation fault |
| faultLevel | output | 1 | 0 = first level, 1 = second level |

## Verification
With a zero-wait memory that answers one cycle after each handshake, a section or first-level fault completes on the second clock edge after acceptance. A two-level walk completes on the fourth. The bench snapshots the cycle counter at acceptance and compares the gap at the `done` sample against the expected two or four. It skips this gap check only in the phase where `memReqReady` is toggled to stall reads. Each descriptor address is compared at the negative edge before the handshake edge it belongs to. Results are compared at the negative edge inside the `done` cycle. Result hold is sampled several cycles after `done` has dropped.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int ADDR_W      = 32;
  localparam int DOM_W       = 4;
  localparam int PERM_W      = 2;
  localparam int L1_BASE_LSB = 14;
  localparam int SECT_LSB    = 20;
  localparam int COARSE_LSB  = 10;
  localparam int FINE_LSB    = 12;
  localparam int L1_BASE_W   = ADDR_W - L1_BASE_LSB;
  localparam int L1_IDX_W    = ADDR_W - SECT_LSB;
  localparam int VLOW_W      = SECT_LSB;

  localparam logic [1:0] L1_FAULT   = 2'd0;
  localparam logic [1:0] L1_COARSE  = 2'd1;
  localparam logic [1:0] L1_SECTION = 2'd2;
  localparam logic [1:0] L1_FINE    = 2'd3;

  localparam logic [1:0] L2_FAULT = 2'd0;
  localparam logic [1:0] L2_LARGE = 2'd1;
  localparam logic [1:0] L2_SMALL = 2'd2;
  localparam logic [1:0] L2_TINY  = 2'd3;

  typedef enum logic [1:0] {
    SZ_1M  = 2'd0,
    SZ_64K = 2'd1,
    SZ_4K  = 2'd2,
    SZ_1K  = 2'd3
  } pageSize_e;

  typedef struct packed {
    logic captureVa;
    logic takeCoarse;
    logic takeFine;
    logic finSection;
    logic finPage;
    logic finFault;
    logic faultLvl;
  } walkCtl_t;

endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  walkCtl_t             ctl,
  input  logic [L1_BASE_W-1:0] baseHi,
  input  logic [ADDR_W-1:0]    reqVaddr,
  input  logic [ADDR_W-1:0]    rspData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 fineTbl,
  output logic [ADDR_W-1:0]    paddr,
  output logic [DOM_W-1:0]     domain,
  output logic [PERM_W-1:0]    perm,
  output logic                 cacheable,
  output logic                 bufferable,
  output logic [1:0]           pageSize,
  output logic                 fault,
  output logic                 faultLevel
);

  logic [VLOW_W-1:0] vaLow;
  logic [ADDR_W-1:0] addrQ;
  logic [DOM_W-1:0]  domQ;
  logic              fineQ;

  logic [ADDR_W-1:0] pgAddr;
  logic [PERM_W-1:0] pgPerm;
  logic [1:0]        pgSel;
  pageSize_e         pgSize;

  assign memAddr = addrQ;
  assign fineTbl = fineQ;

  // second-level result decode
  always_comb begin
    pgAddr = '0;
    pgSel  = 2'd0;
    pgSize = SZ_1K;
    unique case (rspData[1:0])
      L2_LARGE: begin
        pgAddr = {rspData[31:16], vaLow[15:0]};
        pgSel  = vaLow[15:14];
        pgSize = SZ_64K;
      end
      L2_SMALL: begin
        pgAddr = {rspData[31:12], vaLow[11:0]};
        pgSel  = vaLow[11:10];
        pgSize = SZ_4K;
      end
      default: begin
        pgAddr = {rspData[31:10], vaLow[9:0]};
        pgSel  = 2'd0;
        pgSize = SZ_1K;
      end
    endcase
    unique case (pgSel)
      2'd0: pgPerm = rspData[5:4];
      2'd1: pgPerm = rspData[7:6];
      2'd2: pgPerm = rspData[9:8];
      default: pgPerm = rspData[11:10];
    endcase
  end

  // walk state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaLow <= '0;
      addrQ <= '0;
      domQ  <= '0;
      fineQ <= 1'b0;
    end else begin
      if (ctl.captureVa) begin
        vaLow <= reqVaddr[VLOW_W-1:0];
        addrQ <= {baseHi, reqVaddr[ADDR_W-1:SECT_LSB], 2'b00};
      end
      if (ctl.takeCoarse) begin
        addrQ <= {rspData[31:COARSE_LSB], vaLow[19:12], 2'b00};
        domQ  <= rspData[8:5];
        fineQ <= 1'b0;
      end
      if (ctl.takeFine) begin
        addrQ <= {rspData[31:FINE_LSB], vaLow[19:10], 2'b00};
        domQ  <= rspData[8:5];
        fineQ <= 1'b1;
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr      <= '0;
      domain     <= '0;
      perm       <= '0;
      cacheable  <= 1'b0;
      bufferable <= 1'b0;
      pageSize   <= '0;
      fault      <= 1'b0;
      faultLevel <= 1'b0;
    end else if (ctl.finFault) begin
      paddr      <= '0;
      domain     <= '0;
      perm       <= '0;
      cacheable  <= 1'b0;
      bufferable <= 1'b0;
      pageSize   <= '0;
      fault      <= 1'b1;
      faultLevel <= ctl.faultLvl;
    end else if (ctl.finSection) begin
      paddr      <= {rspData[31:SECT_LSB], vaLow};
      domain     <= rspData[8:5];
      perm       <= rspData[11:10];
      cacheable  <= rspData[3];
      bufferable <= rspData[2];
      pageSize   <= SZ_1M;
      fault      <= 1'b0;
      faultLevel <= 1'b0;
    end else if (ctl.finPage) begin
      paddr      <= pgAddr;
      domain     <= domQ;
      perm       <= pgPerm;
      cacheable  <= rspData[3];
      bufferable <= rspData[2];
      pageSize   <= pgSize;
      fault      <= 1'b0;
      faultLevel <= 1'b0;
    end
  end

  AST_TINY_ONLY_FINE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finPage && rspData[1:0] == L2_TINY) |-> fineQ) else $error("tiny page from coarse table"); // R9

  AST_ONE_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.finFault, ctl.finSection, ctl.finPage}) <= 1) else $error("multiple finish strobes"); // R11

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic [1:0] rspType,
  input  logic       fineTbl,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       done,
  output walkCtl_t   ctl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT
  } state_e;

  state_e state, stateNext;

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_L1_REQ) || (state == ST_L2_REQ);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.captureVa = 1'b1;
        stateNext     = ST_L1_REQ;
      end
      ST_L1_REQ: if (memReqReady) stateNext = ST_L1_WAIT;
      ST_L1_WAIT: if (memRspValid) begin
        unique case (rspType)
          L1_FAULT:   begin ctl.finFault = 1'b1; stateNext = ST_IDLE; end
          L1_SECTION: begin ctl.finSection = 1'b1; stateNext = ST_IDLE; end
          L1_COARSE:  begin ctl.takeCoarse = 1'b1; stateNext = ST_L2_REQ; end
          default:    begin ctl.takeFine = 1'b1; stateNext = ST_L2_REQ; end
        endcase
      end
      ST_L2_REQ: if (memReqReady) stateNext = ST_L2_WAIT;
      ST_L2_WAIT: if (memRspValid) begin
        stateNext = ST_IDLE;
        if (rspType == L2_FAULT || (rspType == L2_TINY && !fineTbl)) begin
          ctl.finFault = 1'b1;
          ctl.faultLvl = 1'b1;
        end else begin
          ctl.finPage = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.finFault | ctl.finSection | ctl.finPage;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && memReqValid)) else $error("accept did not start walk"); // R11

  AST_NO_READ_WHEN_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid) else $error("second read issued while one pending"); // R10

endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] tableBase,
  input  logic        reqValid,
  input  logic [31:0] reqVaddr,
  output logic        reqReady,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        done,
  output logic [31:0] paddr,
  output logic [3:0]  domain,
  output logic [1:0]  perm,
  output logic        cacheable,
  output logic        bufferable,
  output logic [1:0]  pageSize,
  output logic        fault,
  output logic        faultLevel
);

  walkCtl_t ctl;
  logic     fineTbl;
  logic     unusedBaseLow;

  assign unusedBaseLow = ^tableBase[L1_BASE_LSB-1:0];

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspType     (memRspData[1:0]),
    .fineTbl     (fineTbl),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .done        (done),
    .ctl         (ctl)
  );

  walk_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .baseHi     (tableBase[ADDR_W-1:L1_BASE_LSB]),
    .reqVaddr   (reqVaddr),
    .rspData    (memRspData),
    .memAddr    (memReqAddr),
    .fineTbl    (fineTbl),
    .paddr      (paddr),
    .domain     (domain),
    .perm       (perm),
    .cacheable  (cacheable),
    .bufferable (bufferable),
    .pageSize   (pageSize),
    .fault      (fault),
    .faultLevel (faultLevel)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))) else $error("read request dropped or changed"); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(paddr) && $stable(fault) && $stable(pageSize) && $stable(perm))) else $error("result moved without done"); // R11

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (paddr == '0 && pageSize == '0 && domain == '0)) else $error("fault with nonzero result"); // R8

endmodule

// File: tb/xlat_walk_bench.sv
module xlat_walk_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tableBase = 32'h0004_3ABC;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        done;
  logic [31:0] paddr;
  logic [3:0]  domain;
  logic [1:0]  perm;
  logic        cacheable, bufferable;
  logic [1:0]  pageSize;
  logic        fault, faultLevel;

  always #10 clk = ~clk;

  xlat_walk u_xlat_walk (
    .clk(clk), .rstN(rstN), .tableBase(tableBase), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .reqReady(reqReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .done(done), .paddr(paddr), .domain(domain),
    .perm(perm), .cacheable(cacheable), .bufferable(bufferable),
    .pageSize(pageSize), .fault(fault), .faultLevel(faultLevel)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int readCount = 0;
  int readSnap = 0;
  int acceptCyc = 0;
  logic stallMode = 1'b0;
  logic readyToggle = 1'b1;

  logic [31:0] mem [int unsigned];

  typedef struct {
    logic [31:0] pa;
    logic [3:0]  dom;
    logic [1:0]  ap;
    logic        c, b;
    logic [1:0]  sz;
    logic        flt, lvl;
    logic [31:0] a1, a2;
    int          reads;
    int          lat;
    string       req;
  } exp_t;

  exp_t q[$];

  assign memReqReady = stallMode ? readyToggle : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    readyToggle <= ~readyToggle;
    memRspValid <= memReqValid && memReqReady;
    memRspData  <= rd(memReqAddr);
    if (memReqValid && memReqReady) readCount <= readCount + 1;
  end

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] l1Addr(logic [31:0] va);
    return {tableBase[31:14], 14'h0} | {18'h0, va[31:20], 2'b00};
  endfunction

  function automatic logic [31:0] l2Addr(logic [31:0] va);
    logic [31:0] d;
    d = rd(l1Addr(va));
    if (d[1:0] == 2'd3) return {d[31:12], 12'h0} | {20'h0, va[19:10], 2'b00};
    return {d[31:10], 10'h0} | {22'h0, va[19:12], 2'b00};
  endfunction

  function automatic logic [1:0] pickAp(logic [31:0] d, logic [1:0] s);
    case (s)
      2'd0: return d[5:4];
      2'd1: return d[7:6];
      2'd2: return d[9:8];
      default: return d[11:10];
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] va, string req);
    exp_t e;
    logic [31:0] d1, d2;
    e.pa = '0; e.dom = '0; e.ap = '0; e.c = 0; e.b = 0; e.sz = '0;
    e.flt = 0; e.lvl = 0; e.a2 = '0; e.req = req;
    e.a1 = l1Addr(va);
    d1 = rd(e.a1);
    e.reads = 1;
    if (d1[1:0] == 2'd0) begin
      e.flt = 1;
    end else if (d1[1:0] == 2'd2) begin
      e.pa = {d1[31:20], va[19:0]}; e.ap = d1[11:10]; e.dom = d1[8:5];
      e.c = d1[3]; e.b = d1[2]; e.sz = 2'd0;
    end else begin
      e.reads = 2;
      e.a2 = l2Addr(va);
      d2 = rd(e.a2);
      if (d2[1:0] == 2'd0 || (d2[1:0] == 2'd3 && d1[1:0] == 2'd1)) begin
        e.flt = 1; e.lvl = 1;
      end else begin
        e.dom = d1[8:5]; e.c = d2[3]; e.b = d2[2];
        if (d2[1:0] == 2'd1) begin
          e.pa = {d2[31:16], va[15:0]}; e.ap = pickAp(d2, va[15:14]); e.sz = 2'd1;
        end else if (d2[1:0] == 2'd2) begin
          e.pa = {d2[31:12], va[11:0]}; e.ap = pickAp(d2, va[11:10]); e.sz = 2'd2;
        end else begin
          e.pa = {d2[31:10], va[9:0]}; e.ap = d2[5:4]; e.sz = 2'd3;
        end
      end
    end
    e.lat = stallMode ? -1 : (e.reads == 1 ? 2 : 4);
    return e;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put1(input logic [31:0] va, input logic [31:0] d);
    mem[l1Addr(va)] = d;
  endtask

  task automatic put2(input logic [31:0] va, input logic [31:0] d);
    mem[l2Addr(va)] = d;
  endtask

  // driver: push expectation, issue request, optionally poke while busy
  task automatic translate(input logic [31:0] va, input string req, input bit poke);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    q.push_back(model(va, req));
    reqVaddr = va;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    acceptCyc = cyc;
    readSnap = readCount;
    if (poke) begin
      for (int i = 0; i < 2; i++) begin
        reqVaddr = va ^ 32'h0FF0_0000;
        reqValid = 1'b1;
        chk(!reqReady, "R11", "reqReady while busy", {31'h0, reqReady}, 32'h0);
        @(negedge clk);
      end
      reqValid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: addresses at each handshake, results at done
  always @(negedge clk) begin
    if (rstN && memReqValid && memReqReady) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10", "read with no walk", memReqAddr, 32'h0);
      end else if (readCount - readSnap == 0) begin
        chk(memReqAddr == q[0].a1, "R2", "first read addr", memReqAddr, q[0].a1);
      end else begin
        chk(memReqAddr == q[0].a2, "R4", "second read addr", memReqAddr, q[0].a2);
      end
    end
    if (rstN && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(fault == e.flt, e.req, "fault", {31'h0, fault}, {31'h0, e.flt});
        chk(faultLevel == e.lvl, e.req, "faultLevel", {31'h0, faultLevel}, {31'h0, e.lvl});
        chk(paddr == e.pa, e.req, "paddr", paddr, e.pa);
        chk(domain == e.dom, e.req, "domain", {28'h0, domain}, {28'h0, e.dom});
        chk(perm == e.ap, e.req, "perm", {30'h0, perm}, {30'h0, e.ap});
        chk({cacheable, bufferable} == {e.c, e.b}, e.req, "C/B",
            {30'h0, cacheable, bufferable}, {30'h0, e.c, e.b});
        chk(pageSize == e.sz, e.req, "pageSize", {30'h0, pageSize}, {30'h0, e.sz});
        chk(readCount - readSnap == e.reads, "R10", "read count",
            readCount - readSnap, e.reads);
        if (e.lat >= 0)
          chk(cyc - acceptCyc == e.lat, "R12", "latency", cyc - acceptCyc, e.lat);
      end
    end
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // table contents
    put1(32'h1234_5678, 32'hABC0_08AA);             // section
    put1(32'h2030_0000, 32'h0008_0521);             // coarse, dom 9
    put1(32'h3000_0000, 32'h000C_1063);             // fine, dom 3
    put2(32'h2034_5C00, 32'h7777_7E4E);             // small
    put2(32'h3001_2345, 32'h5555_5C1B);             // tiny in fine
    put2(32'h3001_0C00, 32'h1357_9B66);             // small in fine
    put2(32'h2030_1000, 32'h1234_5413);             // tiny in coarse
    for (int s = 0; s < 4; s++)
      put2(32'h2036_0123 | (s << 14), 32'hBEEF_0E45); // large, replicated

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady", {31'h0, reqReady}, 32'h1);
    chk(done == 1'b0 && memReqValid == 1'b0, "R1", "done/memReqValid",
        {30'h0, done, memReqValid}, 32'h0);
    chk(paddr == '0 && fault == 1'b0 && pageSize == '0 && perm == '0 && domain == '0,
        "R1", "result regs", paddr, 32'h0);
    rstN = 1'b1;

    translate(32'h1234_5678, "R3", 0);
    translate(32'h0010_0000, "R8", 0);
    translate(32'h2034_5C00, "R6", 1);
    for (int s = 0; s < 4; s++)
      translate(32'h2036_0123 | (s << 14), "R5", 0);
    translate(32'h3001_2345, "R7", 0);
    translate(32'h3001_0C00, "R4", 0);
    translate(32'h2030_1000, "R9", 0);
    translate(32'h2030_2000, "R9", 0);

    // hold after done
    repeat (5) @(negedge clk);
    chk(done == 1'b0 && fault == 1'b1 && faultLevel == 1'b1, "R11", "result held",
        {29'h0, done, fault, faultLevel}, 32'h3);

    // base low bits ignored
    tableBase = 32'h0004_0000;
    translate(32'h1234_5678, "R2", 0);
    tableBase = 32'h0004_3ABC;

    // stalled memory port
    stallMode = 1'b1;
    translate(32'h2034_5C00, "R10", 0);
    translate(32'h3001_2345, "R10", 0);
    translate(32'h1234_5678, "R10", 0);
    stallMode = 1'b0;

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule